// File: doc/BRIEF.md
# In-Order Outbound Read Queue

This block holds up to four outbound cache-line read requests and sends them to the downstream bus master one at a time. Requests go out strictly in the order they arrived. A request stays at the head of the queue until the downstream side answers it with a success response. If the answer is a retry, the same request is sent again, and this repeats with no limit. No later read may go ahead of a head read that was retried.

Between two attempts of a retried read, the block can open a one-cycle window for the posted-write path. If a posted write is pending when the retry arrives, the write path gets a single grant cycle before the read is re-issued. When a read succeeds it leaves the queue, and its tag is reported on a completion output one cycle later.

Top module: `ord_rd_queue`

## Requirements
- R1: The queue holds at most four reads. `full_o` is high exactly while four reads are held. An enqueue offered while `full_o` is high is discarded and is never issued.
- R2: Reads are issued on `rd_req_o` in the order they were enqueued.
- R3: A retry response (`rsp_valid_i`=1, `rsp_ok_i`=0) causes the same head read, with the same address and tag, to be issued again. This repeats for any number of retries.
- R4: After a retry with `wr_pend_i`=1, `wr_grant_o` is high for exactly one cycle, with `rd_req_o` low. The re-issue follows in the next cycle. After a retry with `wr_pend_i`=0, the re-issue comes directly, with no grant.
- R5: While the head read is being retried, `rd_addr_o` and `rd_tag_o` keep showing the head read. No later read is issued.
- R6: The head is removed only on a success response (`rsp_valid_i`=1, `rsp_ok_i`=1). One cycle later, `cmp_valid_o` pulses for one cycle and `cmp_tag_o` carries that read's tag.
- R7: An enqueue in the same cycle as a success response leaves the occupancy unchanged.
- R8: After reset, `rd_req_o`, `wr_grant_o`, `cmp_valid_o` and `full_o` are low.
- R9: `rd_req_o` stays high, and `rd_addr_o` and `rd_tag_o` stay stable, until `rd_ack_i` is seen. A response is expected only after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Offer a read request |
| enq_addr_i | input | ADDR_W | Cache-line address of the offered read |
| enq_tag_i | input | TAG_W | Tag of the offered read |
| full_o | output | 1 | Queue holds DEPTH reads |
| rd_req_o | output | 1 | Head read presented to the downstream master |
| rd_addr_o | output | ADDR_W | Address of the head read |
| rd_tag_o | output | TAG_W | Tag of the head read |
| rd_ack_i | input | 1 | Downstream master has taken the request |
| rsp_valid_i | input | 1 | Response for the outstanding read |
| rsp_ok_i | input | 1 | 1 = success, 0 = retry |
| wr_pend_i | input | 1 | A posted write is waiting |
| wr_grant_o | output | 1 | One-cycle window for the posted-write path |
| cmp_valid_o | output | 1 | A read completed |
| cmp_tag_o | output | TAG_W | Tag of the completed read |

## Verification
The bench retries the head read five times in a row, switching `wr_pend_i` on and off between attempts. A design that let a later read overtake the head, or that changed the head address between attempts, would show a wrong tag on the next issue. A design that gave up after a few retries would show the same fault. A design that granted writes without a pending write, or granted while a read was presented, would be caught by the sampled `wr_grant_o`/`rd_req_o` pair.

The bench offers a fifth read while the queue is full, and then checks that the queue drains empty after four completions. A design that overwrote a slot would complete a stray tag. The bench also enqueues during a success cycle and then checks that exactly one further enqueue raises `full_o`; an occupancy miscount would move that point. Finally, it withholds the acknowledge for several cycles, which exposes a request that drops or changes early.

// File: rtl/ord_rd_pkg.sv
package ord_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } rdq_state_e;
endpackage

// File: rtl/ord_rd_fifo.sv
module ord_rd_fifo #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  occ_q;

  assign full_o      = (occ_q == FULL);
  assign empty_o     = (occ_q == '0);
  assign occ_o       = occ_q;
  assign head_addr_o = addr_q[rptr_q];
  assign head_tag_o  = tag_q[rptr_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[i] <= '0;
        tag_q[i]  <= '0;
      end else if (push_i && wptr_q == PTR_W'(i)) begin
        addr_q[i] <= push_addr_i;
        tag_q[i]  <= push_tag_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      if (push_i && !pop_i)      occ_q <= occ_q + 1'b1;
      else if (pop_i && !push_i) occ_q <= occ_q - 1'b1;
    end
  end
endmodule

// File: rtl/ord_rd_ctrl.sv
module ord_rd_ctrl
  import ord_rd_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             empty_i,
  input  logic [TAG_W-1:0] head_tag_i,
  input  logic             rd_ack_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_ok_i,
  input  logic             wr_pend_i,
  output logic             rd_req_o,
  output logic             wr_grant_o,
  output logic             pop_o,
  output logic             cmp_valid_o,
  output logic [TAG_W-1:0] cmp_tag_o
);
  rdq_state_e st_q, st_d;

  assign rd_req_o   = (st_q == ST_ISSUE);
  assign wr_grant_o = (st_q == ST_GAP);
  assign pop_o      = (st_q == ST_WAIT) && rsp_valid_i && rsp_ok_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (!empty_i) st_d = ST_ISSUE;
      ST_ISSUE: if (rd_ack_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_ok_i)       st_d = ST_IDLE;
          else if (wr_pend_i) st_d = ST_GAP;   // write window between attempts
          else                st_d = ST_ISSUE;
        end
      end
      ST_GAP:   st_d = ST_ISSUE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cmp_valid_o <= 1'b0;
      cmp_tag_o   <= '0;
    end else begin
      st_q        <= st_d;
      cmp_valid_o <= pop_o;
      if (pop_o) cmp_tag_o <= head_tag_i;
    end
  end
endmodule

// File: rtl/ord_rd_queue.sv
module ord_rd_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [ADDR_W-1:0] enq_addr_i,
  input  logic [TAG_W-1:0]  enq_tag_i,
  output logic              full_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  input  logic              rd_ack_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_ok_i,
  input  logic              wr_pend_i,
  output logic              wr_grant_o,
  output logic              cmp_valid_o,
  output logic [TAG_W-1:0]  cmp_tag_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push, pop, empty;
  logic [CNT_W-1:0] occ;

  assign push = enq_valid_i && !full_o;

  ord_rd_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (enq_addr_i),
    .push_tag_i  (enq_tag_i),
    .pop_i       (pop),
    .head_addr_o (rd_addr_o),
    .head_tag_o  (rd_tag_o),
    .occ_o       (occ),
    .full_o      (full_o),
    .empty_o     (empty)
  );

  ord_rd_ctrl #(.TAG_W(TAG_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_i     (empty),
    .head_tag_i  (rd_tag_o),
    .rd_ack_i    (rd_ack_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ok_i    (rsp_ok_i),
    .wr_pend_i   (wr_pend_i),
    .rd_req_o    (rd_req_o),
    .wr_grant_o  (wr_grant_o),
    .pop_o       (pop),
    .cmp_valid_o (cmp_valid_o),
    .cmp_tag_o   (cmp_tag_o)
  );
endmodule

// File: rtl/ord_rd_chk.sv
module ord_rd_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  occ,
  input logic              full_o,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [TAG_W-1:0]  rd_tag_o,
  input logic              rsp_valid_i,
  input logic              rsp_ok_i,
  input logic              wr_pend_i,
  input logic              wr_grant_o,
  input logic              cmp_valid_o,
  input logic [TAG_W-1:0]  cmp_tag_o
);
  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(DEPTH) && (full_o == (occ == CNT_W'(DEPTH))));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_tag_o));

  // R3
  retry_same_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && !rsp_ok_i |=> $stable(rd_addr_o) && $stable(rd_tag_o));

  // R4
  grant_after_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_grant_o |-> $past(rsp_valid_i && !rsp_ok_i && wr_pend_i) && !rd_req_o);

  // R4
  grant_then_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_grant_o |=> rd_req_o && !wr_grant_o);

  // R6
  cmp_on_success_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_o |-> $past(rsp_valid_i && rsp_ok_i) && cmp_tag_o == $past(rd_tag_o));
endmodule

bind ord_rd_queue ord_rd_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) i_ord_rd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .occ         (occ),
  .full_o      (full_o),
  .rd_req_o    (rd_req_o),
  .rd_ack_i    (rd_ack_i),
  .rd_addr_o   (rd_addr_o),
  .rd_tag_o    (rd_tag_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ok_i    (rsp_ok_i),
  .wr_pend_i   (wr_pend_i),
  .wr_grant_o  (wr_grant_o),
  .cmp_valid_o (cmp_valid_o),
  .cmp_tag_o   (cmp_tag_o)
);

// File: tb/test_ord_rd_queue.sv
`timescale 1ns/1ps
module test_ord_rd_queue;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0;
  logic [ADDR_W-1:0] enq_addr = '0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic full, rd_req, wr_grant, cmp_valid;
  logic [ADDR_W-1:0] rd_addr;
  logic [TAG_W-1:0] rd_tag, cmp_tag;
  logic rd_ack = 1'b0, rsp_valid = 1'b0, rsp_ok = 1'b0, wr_pend = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ord_rd_queue i_ord_rd_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_addr_i(enq_addr), .enq_tag_i(enq_tag),
    .full_o(full), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_tag_o(rd_tag),
    .rd_ack_i(rd_ack), .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok),
    .wr_pend_i(wr_pend), .wr_grant_o(wr_grant),
    .cmp_valid_o(cmp_valid), .cmp_tag_o(cmp_tag)
  );

  function automatic logic [ADDR_W-1:0] addr_of(input logic [TAG_W-1:0] t);
    return ADDR_W'(t) << 6;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic enqueue(input logic [TAG_W-1:0] t);
    @(negedge clk);
    enq_valid = 1'b1; enq_tag = t; enq_addr = addr_of(t);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  // one attempt of the head read; checks issue, then result of the response
  task automatic attempt(input logic [TAG_W-1:0] exp_tag, input bit ok, input bit pend,
                         input bit do_enq, input logic [TAG_W-1:0] etag);
    int n = 0;
    @(negedge clk);
    while (!rd_req && n < 20) begin @(negedge clk); n++; end
    check(rd_req, "R2", "issue seen", rd_req, 1);
    check(rd_tag == exp_tag, "R2", "issued tag order", rd_tag, exp_tag);
    check(rd_addr == addr_of(exp_tag), "R5", "head address", rd_addr, addr_of(exp_tag));
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0; rsp_valid = 1'b1; rsp_ok = ok; wr_pend = pend;
    if (do_enq) begin enq_valid = 1'b1; enq_tag = etag; enq_addr = addr_of(etag); end
    @(negedge clk);
    rsp_valid = 1'b0; enq_valid = 1'b0;
    if (ok) begin
      check(cmp_valid && cmp_tag == exp_tag, "R6", "completion tag", cmp_tag, exp_tag);
    end else if (pend) begin
      check(wr_grant && !rd_req, "R4", "write window after retry", {wr_grant, rd_req}, 2'b10);
      @(negedge clk);
      check(!wr_grant && rd_req, "R4", "re-issue after window", {wr_grant, rd_req}, 2'b01);
      check(rd_tag == exp_tag, "R3", "same head re-issued", rd_tag, exp_tag);
    end else begin
      check(!wr_grant && rd_req, "R4", "direct re-issue", {wr_grant, rd_req}, 2'b01);
      check(rd_tag == exp_tag && !cmp_valid, "R3", "same head, no completion", rd_tag, exp_tag);
    end
    wr_pend = 1'b0;
  endtask

  task automatic t_reset;
    check(!rd_req && !wr_grant && !cmp_valid && !full, "R8", "reset outputs",
          {rd_req, wr_grant, cmp_valid, full}, 0);
  endtask

  task automatic t_fill_retry;
    for (int i = 1; i <= 4; i++) enqueue(TAG_W'(i));
    check(full, "R1", "full after four", full, 1);
    enqueue(4'd9);  // refused
    check(full, "R1", "still full", full, 1);
    attempt(4'd1, 1'b0, 1'b1, 1'b0, '0);
    attempt(4'd1, 1'b0, 1'b0, 1'b0, '0);
    attempt(4'd1, 1'b0, 1'b1, 1'b0, '0);
    attempt(4'd1, 1'b0, 1'b0, 1'b0, '0);
    attempt(4'd1, 1'b0, 1'b1, 1'b0, '0);
    check(full, "R6", "no dequeue on retry", full, 1);
    attempt(4'd1, 1'b1, 1'b0, 1'b0, '0);
    attempt(4'd2, 1'b1, 1'b1, 1'b0, '0);
    attempt(4'd3, 1'b1, 1'b0, 1'b0, '0);
    attempt(4'd4, 1'b1, 1'b0, 1'b0, '0);
    repeat (5) @(negedge clk);
    check(!rd_req && !full, "R1", "refused read never issued", rd_req, 0);
  endtask

  task automatic t_hold;
    enqueue(4'd5);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rd_req && rd_addr == addr_of(4'd5) && rd_tag == 4'd5, "R9",
            "request held without ack", rd_addr, addr_of(4'd5));
    end
    attempt(4'd5, 1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic t_enq_deq;
    enqueue(4'd10); enqueue(4'd11); enqueue(4'd12);
    check(!full, "R7", "three held", full, 0);
    attempt(4'd10, 1'b1, 1'b0, 1'b1, 4'd13);
    check(!full, "R7", "occupancy kept at three", full, 0);
    enqueue(4'd14);
    check(full, "R7", "one more fills", full, 1);
    attempt(4'd11, 1'b1, 1'b0, 1'b0, '0);
    attempt(4'd12, 1'b1, 1'b0, 1'b0, '0);
    attempt(4'd13, 1'b1, 1'b0, 1'b0, '0);
    attempt(4'd14, 1'b1, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_retry();
    t_hold();
    t_enq_deq();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule